// File: doc/BRIEF.md
# Cycle-Stealing Event Transfer Engine

The engine provides eight transfer channels that serve hardware events without running a software handler. Each channel keeps a source pointer, a destination pointer, a transfer counter and a small control word. When an event line for a channel pulses, the engine takes one bus cycle from the CPU. In that cycle it reads one item from the source address and writes it to the destination address. It then advances one of the two pointers and, unless the channel is in continuous mode, counts the counter down.

A channel whose counter has already run out, and which is not in continuous mode, does no transfer. The next event on that channel becomes a one-cycle interrupt request on that channel's line, so a normal vectored handler can take over.

Channels are loaded through a configuration write port that writes one whole channel at a time. The memory side is a single port with a combinational read and a write on the clock edge, so the read and the write of one item both fit in the stolen cycle.

Top module: `evt_xfer_engine`

## Requirements
- R1: After synchronous reset, `cpu_hold`, `mem_we` and `irq` are low, no event is pending, and all channel pointers, counters and controls are zero.
- R2: An event pulse on `trig[i]` sampled at a clock edge produces a service in the following cycle. A transferring service raises `cpu_hold` and `mem_we` for exactly that one cycle, and `mem_wdata` equals the value read from `mem_rd_addr`.
- R3: With the control size bit `cfg_word`=0, the access is a byte (`mem_word`=0), `mem_wdata[15:8]` is zero, and the selected pointer advances by 1 per service.
- R4: With `cfg_word`=1, the access is a 16-bit word (`mem_word`=1) and the selected pointer advances by 2 per service.
- R5: `mem_rd_addr` shows the source pointer and `mem_wr_addr` shows the destination pointer. After a service, only the destination pointer advances if `cfg_inc_dst`=1, and only the source pointer advances if it is 0.
- R6: Outside continuous mode, each transfer lowers the channel's counter by one. A channel loaded with count N therefore performs N transfers before its next event raises an interrupt.
- R7: With `cfg_cont`=1, the counter is never changed, every event transfers, even at count zero, and the channel never raises `irq`.
- R8: An event on a non-continuous channel whose counter is zero performs no bus access (`cpu_hold`=0, `mem_we`=0). Instead it pulses `irq[i]` for that one service cycle, and the pointers stay unchanged.
- R9: Events pending on several channels are served one per cycle, with the lowest-numbered channel first. At most one `irq` bit is set in any cycle.
- R10: When no event is pending, `cpu_hold` is low in the cycle after the last service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | NCH | Event pulse, one bit per channel |
| cfg_we | input | 1 | Load the channel selected by cfg_chan |
| cfg_chan | input | IW | Channel number to load |
| cfg_src | input | AW | Source pointer value to load |
| cfg_dst | input | AW | Destination pointer value to load |
| cfg_cnt | input | CW | Transfer count to load |
| cfg_word | input | 1 | 1 = word items, 0 = byte items |
| cfg_inc_dst | input | 1 | 1 = advance destination, 0 = advance source |
| cfg_cont | input | 1 | Continuous mode, counter left unchanged |
| cpu_hold | output | 1 | Holds the CPU off during the stolen cycle |
| mem_rd_addr | output | AW | Read address (source pointer) |
| mem_wr_addr | output | AW | Write address (destination pointer) |
| mem_word | output | 1 | Access size for both read and write |
| mem_we | output | 1 | Write strobe, taken at the clock edge |
| mem_rdata | input | 16 | Combinational read data |
| mem_wdata | output | 16 | Write data |
| irq | output | NCH | One-cycle interrupt request per channel |

## Verification
The bench targets the boundary where a counter moves from one to zero. A design that checks the count after decrementing would raise the interrupt one transfer early, and one that never stops would keep writing. Continuous channels loaded with count zero are exercised to catch a design that lets the zero test win over the mode bit, which would wrongly fire `irq`. Bursts of events on several channels check the lowest-first order and that no event is dropped; a wrong arbiter shows up as swapped addresses. Mixed byte and word channels with either pointer advancing catch a wrong step size, a wrong pointer being moved, and junk in the high data byte.

// File: rtl/evt_xfer_pkg.sv
package evt_xfer_pkg;

    typedef struct packed {
        logic cont;
        logic inc_dst;
        logic word;
    } xfer_ctl_t;

    function automatic logic [1:0] step_bytes(input logic word);
        return word ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/evt_xfer_arb.sv
module evt_xfer_arb #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                gnt[i] = 1'b1;
                idx    = IW'(i);
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/evt_xfer_chan.sv
module evt_xfer_chan
    import evt_xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] ld_src,
    input  logic [AW-1:0] ld_dst,
    input  logic [CW-1:0] ld_cnt,
    input  xfer_ctl_t     ld_ctl,
    input  logic          svc,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [CW-1:0] cnt_q,
    output xfer_ctl_t     ctl_q
);
    logic          moves;
    logic [AW-1:0] step;

    assign moves = svc && (ctl_q.cont || (cnt_q != '0));
    assign step  = AW'(step_bytes(ctl_q.word));

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
            ctl_q <= '0;
        end else if (load) begin
            src_q <= ld_src;
            dst_q <= ld_dst;
            cnt_q <= ld_cnt;
            ctl_q <= ld_ctl;
        end else if (moves) begin
            if (ctl_q.inc_dst) dst_q <= dst_q + step;
            else               src_q <= src_q + step;
            if (!ctl_q.cont)   cnt_q <= cnt_q - CW'(1);
        end
    end
endmodule

// File: rtl/evt_xfer_engine.sv
module evt_xfer_engine
    import evt_xfer_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 16,
    parameter int CW  = 8,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] trig,
    input  logic           cfg_we,
    input  logic [IW-1:0]  cfg_chan,
    input  logic [AW-1:0]  cfg_src,
    input  logic [AW-1:0]  cfg_dst,
    input  logic [CW-1:0]  cfg_cnt,
    input  logic           cfg_word,
    input  logic           cfg_inc_dst,
    input  logic           cfg_cont,
    output logic           cpu_hold,
    output logic [AW-1:0]  mem_rd_addr,
    output logic [AW-1:0]  mem_wr_addr,
    output logic           mem_word,
    output logic           mem_we,
    input  logic [15:0]    mem_rdata,
    output logic [15:0]    mem_wdata,
    output logic [NCH-1:0] irq
);
    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] gnt;
    logic [IW-1:0]  gidx;
    logic           any;

    logic [AW-1:0]  src_q [NCH];
    logic [AW-1:0]  dst_q [NCH];
    logic [CW-1:0]  cnt_q [NCH];
    xfer_ctl_t      ctl_q [NCH];
    logic [NCH-1:0] cont_vec;

    xfer_ctl_t      ld_ctl;
    xfer_ctl_t      ctl_sel;
    logic [CW-1:0]  cnt_sel;
    logic           xfer;

    assign ld_ctl = '{cont: cfg_cont, inc_dst: cfg_inc_dst, word: cfg_word};

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~gnt) | trig;
    end

    evt_xfer_arb #(.N(NCH)) u_arb (
        .req (pend_q),
        .gnt (gnt),
        .idx (gidx),
        .any (any)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        evt_xfer_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .load   (cfg_we && (cfg_chan == IW'(c))),
            .ld_src (cfg_src),
            .ld_dst (cfg_dst),
            .ld_cnt (cfg_cnt),
            .ld_ctl (ld_ctl),
            .svc    (gnt[c]),
            .src_q  (src_q[c]),
            .dst_q  (dst_q[c]),
            .cnt_q  (cnt_q[c]),
            .ctl_q  (ctl_q[c])
        );
        assign cont_vec[c] = ctl_q[c].cont;
    end

    assign ctl_sel = ctl_q[gidx];
    assign cnt_sel = cnt_q[gidx];
    assign xfer    = any && (ctl_sel.cont || (cnt_sel != '0));

    assign cpu_hold    = xfer;
    assign mem_we      = xfer;
    assign mem_rd_addr = src_q[gidx];
    assign mem_wr_addr = dst_q[gidx];
    assign mem_word    = ctl_sel.word;
    assign mem_wdata   = ctl_sel.word ? mem_rdata : {8'h00, mem_rdata[7:0]};
    assign irq         = (any && !xfer) ? gnt : '0;
endmodule

// File: rtl/evt_xfer_chk.sv
module evt_xfer_chk #(
    parameter int NCH = 8,
    parameter int CW  = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           cpu_hold,
    input logic           mem_we,
    input logic [NCH-1:0] irq,
    input logic [NCH-1:0] pend_q,
    input logic [NCH-1:0] cont_vec,
    input logic [CW-1:0]  cnt_sel,
    input logic           cont_sel
);
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cpu_hold && !mem_we && irq == '0)); // R1

    AST_SERVICE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        (cpu_hold || irq != '0) |-> pend_q != '0); // R2

    AST_CONT_NEVER_IRQ: assert property (@(posedge clk) disable iff (rst)
        (irq & cont_vec) == '0); // R7

    AST_ZERO_COUNT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        (irq != '0) |-> (!cpu_hold && !mem_we)); // R8

    AST_MOVE_NEEDS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (cpu_hold && !cont_sel) |-> cnt_sel != '0); // R6

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq)); // R9
endmodule

bind evt_xfer_engine evt_xfer_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_hold (cpu_hold),
    .mem_we   (mem_we),
    .irq      (irq),
    .pend_q   (pend_q),
    .cont_vec (cont_vec),
    .cnt_sel  (cnt_sel),
    .cont_sel (ctl_sel.cont)
);

// File: tb/evt_xfer_engine_bench.sv
`timescale 1ns/1ps
module evt_xfer_engine_bench;
    localparam int NCH = 8;
    localparam int AW  = 16;
    localparam int CW  = 8;
    localparam int IW  = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] trig = '0;
    logic           cfg_we = 1'b0;
    logic [IW-1:0]  cfg_chan = '0;
    logic [AW-1:0]  cfg_src = '0, cfg_dst = '0;
    logic [CW-1:0]  cfg_cnt = '0;
    logic           cfg_word = 1'b0, cfg_inc_dst = 1'b0, cfg_cont = 1'b0;
    logic           cpu_hold, mem_word, mem_we;
    logic [AW-1:0]  mem_rd_addr, mem_wr_addr;
    logic [15:0]    mem_rdata, mem_wdata;
    logic [NCH-1:0] irq;

    logic [7:0] mem [256];

    int tests = 0;
    int fails = 0;

    logic [AW-1:0] m_src [NCH];
    logic [AW-1:0] m_dst [NCH];
    logic [CW-1:0] m_cnt [NCH];
    logic          m_word [NCH];
    logic          m_incd [NCH];
    logic          m_cont [NCH];

    always #2 clk = ~clk;

    evt_xfer_engine u_evt_xfer_engine (
        .clk(clk), .rst(rst), .trig(trig),
        .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .cfg_cnt(cfg_cnt), .cfg_word(cfg_word), .cfg_inc_dst(cfg_inc_dst), .cfg_cont(cfg_cont),
        .cpu_hold(cpu_hold), .mem_rd_addr(mem_rd_addr), .mem_wr_addr(mem_wr_addr),
        .mem_word(mem_word), .mem_we(mem_we), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .irq(irq)
    );

    always_comb begin
        if (mem_word) mem_rdata = {mem[mem_rd_addr[7:0] + 8'd1], mem[mem_rd_addr[7:0]]};
        else          mem_rdata = {8'h00, mem[mem_rd_addr[7:0]]};
    end

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_wr_addr[7:0]] <= mem_wdata[7:0];
            if (mem_word) mem[mem_wr_addr[7:0] + 8'd1] <= mem_wdata[15:8];
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_item(input logic [AW-1:0] a, input logic w);
        return w ? {mem[a[7:0] + 8'd1], mem[a[7:0]]} : {8'h00, mem[a[7:0]]};
    endfunction

    task automatic load(input int ch, input logic [AW-1:0] s, input logic [AW-1:0] d,
                        input logic [CW-1:0] n, input logic w, input logic incd, input logic ct);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = IW'(ch); cfg_src = s; cfg_dst = d; cfg_cnt = n;
        cfg_word = w; cfg_inc_dst = incd; cfg_cont = ct;
        @(negedge clk);
        cfg_we = 1'b0;
        m_src[ch] = s; m_dst[ch] = d; m_cnt[ch] = n;
        m_word[ch] = w; m_incd[ch] = incd; m_cont[ch] = ct;
    endtask

    // Called at a negedge inside the service cycle of channel ch.
    task automatic svc_check(input int ch, input string order_tag);
        logic moves;
        logic [AW-1:0] step;
        moves = m_cont[ch] || (m_cnt[ch] != '0);
        if (moves) begin
            chk("R2 hold", {31'd0, cpu_hold}, 32'd1);
            chk("R2 we", {31'd0, mem_we}, 32'd1);
            chk({order_tag, " src"}, {16'd0, mem_rd_addr}, {16'd0, m_src[ch]});
            chk("R5 dst", {16'd0, mem_wr_addr}, {16'd0, m_dst[ch]});
            chk(m_word[ch] ? "R4 size" : "R3 size", {31'd0, mem_word}, {31'd0, m_word[ch]});
            chk(m_word[ch] ? "R4 data" : "R3 data", {16'd0, mem_wdata},
                {16'd0, exp_item(m_src[ch], m_word[ch])});
            chk(m_cont[ch] ? "R7 irq" : "R6 irq", {24'd0, irq}, 32'd0);
            step = m_word[ch] ? AW'(2) : AW'(1);
            if (m_incd[ch]) m_dst[ch] = m_dst[ch] + step;
            else            m_src[ch] = m_src[ch] + step;
            if (!m_cont[ch]) m_cnt[ch] = m_cnt[ch] - CW'(1);
        end else begin
            chk("R8 hold", {31'd0, cpu_hold}, 32'd0);
            chk("R8 we", {31'd0, mem_we}, 32'd0);
            chk("R8 irq", {24'd0, irq}, 32'd1 << ch);
        end
    endtask

    task automatic fire(input logic [NCH-1:0] mask);
        string ot;
        ot = ($countones(mask) > 1) ? "R9" : "R5";
        @(negedge clk);
        trig = mask;
        @(negedge clk);
        trig = '0;
        for (int c = 0; c < NCH; c++) begin
            if (mask[c]) begin
                svc_check(c, ot);
                @(negedge clk);
            end
        end
        chk("R10 idle hold", {31'd0, cpu_hold}, 32'd0);
        chk("R10 idle irq", {24'd0, irq}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'h5eed1234;
        void'($urandom(seed));
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 2));
        for (int c = 0; c < NCH; c++) begin
            m_src[c] = '0; m_dst[c] = '0; m_cnt[c] = '0;
            m_word[c] = 1'b0; m_incd[c] = 1'b0; m_cont[c] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle outputs after reset
        chk("R1 hold", {31'd0, cpu_hold}, 32'd0);
        chk("R1 we", {31'd0, mem_we}, 32'd0);
        chk("R1 irq", {24'd0, irq}, 32'd0);
        // R1 / R8: unloaded channel has count zero, so an event interrupts
        fire(8'b0000_1000);

        // R3, R6: byte channel, source advances, count 3 then interrupt
        load(0, 16'h0010, 16'h0080, 8'd3, 1'b0, 1'b0, 1'b0);
        repeat (4) fire(8'b0000_0001);
        // R4, R5: word channel, destination advances
        load(1, 16'h0020, 16'h0090, 8'd2, 1'b1, 1'b1, 1'b0);
        repeat (3) fire(8'b0000_0010);
        // R7: continuous channel loaded with count zero keeps moving
        load(2, 16'h0040, 16'h00C0, 8'd0, 1'b0, 1'b1, 1'b1);
        repeat (5) fire(8'b0000_0100);
        // R8: count one, one move then interrupt, pointers unchanged after
        load(5, 16'h0050, 16'h00D0, 8'd1, 1'b1, 1'b0, 1'b0);
        fire(8'b0010_0000);
        fire(8'b0010_0000);
        fire(8'b0010_0000);
        // R9: simultaneous events, lowest first
        load(7, 16'h0060, 16'h00E0, 8'd4, 1'b0, 1'b1, 1'b0);
        load(4, 16'h0070, 16'h00F0, 8'd4, 1'b1, 1'b0, 1'b0);
        fire(8'b1011_0110);
        fire(8'b1111_1111);

        // Random mix
        for (int it = 0; it < 300; it++) begin
            if ($urandom_range(0, 3) == 0) begin
                load(int'($urandom_range(0, NCH - 1)), AW'($urandom_range(0, 255)),
                     AW'($urandom_range(0, 255)), CW'($urandom_range(0, 4)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 5) == 0));
            end
            fire(NCH'($urandom_range(1, 255)));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule